// File: doc/BRIEF.md
# UART Interrupt Cause Collector

This unit gathers the interrupt sources of a high-speed UART into one sticky cause mask. Five sources can be pending at the same moment: a receive line error, enough receive data, a receive character timeout, free transmit space, and a change on the modem inputs. Software reads a packed 32-bit status word to see these sources. It clears any subset of them by writing a byte back. A single interrupt line is the OR of the pending causes that are enabled.

The unit takes two FIFO fill counts and compares each one against a threshold. The threshold is chosen by a 3-bit level. The unit also watches four modem inputs and keeps a delta flag for each. It latches line error events, such as overrun and framing, until the line status cause is cleared. The status word also carries the receive fill count, split into high and low parts.

Top module: `uart_irq_unit`

## Requirements
- R1: `status[4:0]` is the cause mask, with one bit per source: bit0 line error, bit1 receive data, bit2 receive timeout, bit3 transmit space, bit4 modem change. A cause bit becomes 1 on the clock edge after its event. It stays 1 until it is cleared, and several bits can be 1 together.
- R2: A clock edge with `wr_en` high clears each cause bit whose bit in `wr_byte[4:0]` is 1. Bits `wr_byte[7:5]` have no effect. If a new event for a cause arrives on the same edge as the clear, the event wins and the bit stays 1.
- R3: The receive data event is the rising edge of `rx_count >= (4 << rx_lvl)`. For example, level 5 means a threshold of 128 bytes.
- R4: The transmit space event is the rising edge of `tx_count < (4 << tx_lvl)`.
- R5: The receive timeout event is the rising edge of `rx_timeout`. Holding `rx_timeout` high does not set the cause again after it is cleared.
- R6: `status[15:8]` is the modem byte. Bits [11:8] are the delta flags and bits [15:12] are the levels registered one cycle earlier, both in the order CTS, DSR, RI, DCD. Any change on an input sets its delta flag and cause bit4. Clearing bit4 also clears all four delta flags.
- R7: `status[23:16]` is the line byte, from bit16 to bit23:
  - bit16: data ready (`rx_count != 0`)
  - bits 17 to 20: overrun, parity, framing and break
  - bit21: transmit holding empty (`tx_count == 0`)
  - bit22: transmitter empty (holding empty and `!tx_busy`)
  - bit23: receive FIFO error
  
  The error flags come from `err_evt` bits 0 to 4, in the order overrun, parity, framing, break, FIFO error. Each flag is sticky and sets cause bit0. Clearing bit0 also clears the flags.
- R8: `irq` is high when a pending cause is enabled. `irq_en[0]` enables bits 1 and 2, `irq_en[1]` enables bit3, `irq_en[2]` enables bit0, and `irq_en[3]` enables bit4. Enables act without delay and do not change the mask.
- R9: `status[7:6]` shows `rx_count[9:8]`, `status[31:24]` shows `rx_count[7:0]`, and `status[5]` reads 0.
- R10: Reset is synchronous and active high. It clears causes, delta flags and error flags. No event is reported for input levels that were held steady through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 4 | Interrupt enables (receive, tx space, line, modem) |
| tx_lvl | input | 3 | Transmit trigger level |
| rx_lvl | input | 3 | Receive trigger level |
| rx_count | input | 10 | Receive FIFO fill count |
| tx_count | input | 10 | Transmit FIFO fill count |
| tx_busy | input | 1 | Transmit shifter active |
| rx_timeout | input | 1 | Character timeout condition |
| err_evt | input | 5 | Line error event pulses |
| modem_in | input | 4 | CTS, DSR, RI, DCD levels |
| wr_en | input | 1 | Status byte write strobe |
| wr_byte | input | 8 | Byte written to status bits [7:0] |
| status | output | 32 | Packed status word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong edge-detector state shows up one edge after a threshold crossing: either a lost cause bit or a duplicate cause bit after a clear. A stale delta flag or error flag shows in the modem or line byte right after the clear write that should have removed it. A broken enable map shows on `irq` in the same cycle the enables change. The bench therefore compares every field of the status word and `irq` on every cycle, while random counts cross the thresholds and random writes clear causes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int CNT_W  = 10;
    localparam int LVL_W  = 3;
    localparam int NCAUSE = 5;
    localparam int NMDM   = 4;
    localparam int NERR   = 5;
    localparam int NEDGE  = 3;

    typedef enum int unsigned {
        C_LINE = 0, C_RXDATA = 1, C_RXTMO = 2, C_TXSPACE = 3, C_MODEM = 4
    } cause_e;

    typedef struct packed {
        logic rxfifo_err;
        logic tx_empty;
        logic thr_empty;
        logic brk;
        logic framing;
        logic parity;
        logic overrun;
        logic data_rdy;
    } line_byte_t;

    typedef struct packed {
        logic [NMDM-1:0] lvl;
        logic [NMDM-1:0] delta;
    } modem_byte_t;

    typedef struct packed {
        logic [7:0]        cnt_lo;
        line_byte_t        line;
        modem_byte_t       modem;
        logic [1:0]        cnt_hi;
        logic              rsvd;
        logic [NCAUSE-1:0] cause;
    } status_t;

    function automatic logic [CNT_W-1:0] lvl_thr(input logic [LVL_W-1:0] lvl);
        return CNT_W'(4) << lvl;
    endfunction

    function automatic logic [NCAUSE-1:0] en_map(input logic [3:0] en);
        return {en[3], en[1], en[0], en[0], en[2]};
    endfunction
endpackage

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) prev_q[i] <= cond[i];
        assign rise[i] = cond[i] & ~prev_q[i];
    end

    // R3: a rising edge is reported for a single cycle only
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NMDM-1:0] modem_in,
    input  logic            clr,
    output logic [NMDM-1:0] lvl_q,
    output logic [NMDM-1:0] delta_q,
    output logic            chg
);
    logic [NMDM-1:0] diff;

    assign diff = modem_in ^ lvl_q;
    assign chg  = |diff;

    always_ff @(posedge clk) lvl_q <= modem_in;

    always_ff @(posedge clk) begin
        if (rst) delta_q <= '0;
        else     delta_q <= (delta_q & ~{NMDM{clr}}) | diff;
    end

    assert_delta_set_R6: assert property (@(posedge clk) disable iff (rst)
        (diff != '0) |=> ((delta_q & $past(diff)) == $past(diff)));
endmodule

// File: rtl/uart_irq_line.sv
module uart_irq_line
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NERR-1:0] err_evt,
    input  logic            clr,
    output logic [NERR-1:0] err_q
);
    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= (err_q & ~{NERR{clr}}) | err_evt;
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_evt != '0) |=> ((err_q & $past(err_evt)) == $past(err_evt)));
endmodule

// File: rtl/uart_irq_cause.sv
module uart_irq_cause
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] set_vec,
    input  logic [NCAUSE-1:0] clr_vec,
    output logic [NCAUSE-1:0] pending
);
    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= (pending & ~clr_vec) | set_vec;
    end

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec)));

    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (clr_vec == '0) |=> ((pending & $past(pending)) == $past(pending)));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec & ~set_vec) != '0) |=> ((pending & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       irq_en,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_busy,
    input  logic             rx_timeout,
    input  logic [NERR-1:0]  err_evt,
    input  logic [NMDM-1:0]  modem_in,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    output logic [31:0]      status,
    output logic             irq
);
    logic [NEDGE-1:0]  cond, rise;
    logic [NCAUSE-1:0] set_vec, clr_vec, pending;
    logic [NMDM-1:0]   lvl_q, delta_q;
    logic [NERR-1:0]   err_q;
    logic              mdm_chg;
    logic              unused_wr_hi;
    status_t           st;

    assign unused_wr_hi = ^wr_byte[7:NCAUSE];

    // edge sources: 0 receive data, 1 timeout, 2 transmit space
    assign cond[0] = rx_count >= lvl_thr(rx_lvl);
    assign cond[1] = rx_timeout;
    assign cond[2] = tx_count < lvl_thr(tx_lvl);

    uart_irq_edge #(.W(NEDGE)) u_edge (
        .clk(clk), .rst(rst), .cond(cond), .rise(rise)
    );

    assign clr_vec = wr_en ? wr_byte[NCAUSE-1:0] : '0;

    uart_irq_modem u_modem (
        .clk(clk), .rst(rst), .modem_in(modem_in), .clr(clr_vec[C_MODEM]),
        .lvl_q(lvl_q), .delta_q(delta_q), .chg(mdm_chg)
    );

    uart_irq_line u_line (
        .clk(clk), .rst(rst), .err_evt(err_evt), .clr(clr_vec[C_LINE]),
        .err_q(err_q)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[C_LINE]    = |err_evt;
        set_vec[C_RXDATA]  = rise[0];
        set_vec[C_RXTMO]   = rise[1];
        set_vec[C_TXSPACE] = rise[2];
        set_vec[C_MODEM]   = mdm_chg;
    end

    uart_irq_cause u_cause (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
        .pending(pending)
    );

    always_comb begin
        st                 = '0;
        st.cause           = pending;
        st.cnt_hi          = rx_count[9:8];
        st.cnt_lo          = rx_count[7:0];
        st.modem.lvl       = lvl_q;
        st.modem.delta     = delta_q;
        st.line.data_rdy   = rx_count != '0;
        st.line.overrun    = err_q[0];
        st.line.parity     = err_q[1];
        st.line.framing    = err_q[2];
        st.line.brk        = err_q[3];
        st.line.rxfifo_err = err_q[4];
        st.line.thr_empty  = tx_count == '0;
        st.line.tx_empty   = (tx_count == '0) && !tx_busy;
    end

    assign status = st;
    assign irq    = |(pending & en_map(irq_en));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status[NCAUSE-1:0] != '0));

    assert_delta_with_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (delta_q != '0) |-> pending[C_MODEM] || $past(wr_en));
endmodule

// File: tb/test_uart_irq_unit.sv
module test_uart_irq_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  irq_en;
    logic [2:0]  tx_lvl, rx_lvl;
    logic [9:0]  rx_count, tx_count;
    logic        tx_busy, rx_timeout;
    logic [4:0]  err_evt;
    logic [3:0]  modem_in;
    logic        wr_en;
    logic [7:0]  wr_byte;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_unit i_uart_irq_unit (
        .clk(clk), .rst(rst), .irq_en(irq_en), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .rx_count(rx_count), .tx_count(tx_count), .tx_busy(tx_busy),
        .rx_timeout(rx_timeout), .err_evt(err_evt), .modem_in(modem_in),
        .wr_en(wr_en), .wr_byte(wr_byte), .status(status), .irq(irq)
    );

    // reference state
    logic [4:0] m_pend, m_err;
    logic [3:0] m_delta, m_lvl;
    logic       m_prda, m_ptmo, m_ptsa;

    function automatic logic [9:0] thr(input logic [2:0] l);
        return 10'd4 << l;
    endfunction

    task automatic m_step();
        logic rda, tsa;
        logic [3:0] ch;
        logic [4:0] set, clr;
        rda = rx_count >= thr(rx_lvl);
        tsa = tx_count < thr(tx_lvl);
        ch  = modem_in ^ m_lvl;
        if (rst) begin
            m_pend = '0; m_err = '0; m_delta = '0;
        end else begin
            set = {|ch, tsa & ~m_ptsa, rx_timeout & ~m_ptmo, rda & ~m_prda, |err_evt};
            clr = wr_en ? wr_byte[4:0] : 5'd0;
            m_pend  = (m_pend & ~clr) | set;
            m_delta = (m_delta & ~{4{clr[4]}}) | ch;
            m_err   = (m_err & ~{5{clr[0]}}) | err_evt;
        end
        m_prda = rda; m_ptmo = rx_timeout; m_ptsa = tsa; m_lvl = modem_in;
    endtask

    function automatic logic [7:0] m_line();
        logic thre;
        thre = tx_count == 10'd0;
        return {m_err[4], thre & ~tx_busy, thre, m_err[3], m_err[2], m_err[1], m_err[0], rx_count != 10'd0};
    endfunction

    function automatic logic m_irq();
        return |(m_pend & {irq_en[3], irq_en[1], irq_en[0], irq_en[0], irq_en[2]});
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1; wr_byte = b;
        cyc();
        wr_en = 1'b0; wr_byte = 8'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; irq_en = 4'hF; tx_lvl = 3'd0; rx_lvl = 3'd5;
        rx_count = '0; tx_count = '0; tx_busy = 1'b0; rx_timeout = 1'b0;
        err_evt = '0; modem_in = '0; wr_en = 1'b0; wr_byte = '0;
        m_pend = '0; m_err = '0; m_delta = '0; m_lvl = '0;
        m_prda = 1'b0; m_ptmo = 1'b0; m_ptsa = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R10: nothing pending after reset, empty transmit FIFO gives no event
        chk("R10 cause", {27'd0, status[4:0]}, 32'd0);
        chk("R10 irq", {31'd0, irq}, 32'd0);

        // R3: threshold 128 at level 5
        rx_count = 10'd127; cyc();
        chk("R3 below", {31'd0, status[1]}, 32'd0);
        rx_count = 10'd128; cyc();
        chk("R3 at", {31'd0, status[1]}, 32'd1);
        chk("R8 rx irq", {31'd0, irq}, 32'd1);

        // R2: upper byte bits do not clear; R9 count bits
        wr(8'hE0);
        chk("R2 upper", {27'd0, status[4:0]}, 32'h2);
        chk("R9 cnt", {24'd0, status[31:24]}, 32'h80);
        chk("R9 hi", {30'd0, status[7:6]}, 32'd0);
        wr(8'h02);
        chk("R2 clear", {27'd0, status[4:0]}, 32'd0);
        chk("R8 idle", {31'd0, irq}, 32'd0);

        // R4: fill 10 then 3 with threshold 4
        tx_count = 10'd10; cyc();
        chk("R4 above", {31'd0, status[3]}, 32'd0);
        tx_count = 10'd3; cyc();
        chk("R4 below", {31'd0, status[3]}, 32'd1);
        wr(8'h08);

        // R5: timeout edge only
        rx_timeout = 1'b1; cyc();
        chk("R5 rise", {31'd0, status[2]}, 32'd1);
        wr(8'h04);
        cyc();
        chk("R5 held", {31'd0, status[2]}, 32'd0);
        // R2: event beats clear on the same edge
        rx_timeout = 1'b0; cyc();
        rx_timeout = 1'b1; wr(8'h04);
        chk("R2 collide", {31'd0, status[2]}, 32'd1);
        wr(8'h04);

        // R6: modem deltas and levels
        modem_in = 4'b0101; cyc();
        chk("R6 byte", {24'd0, status[15:8]}, 32'h55);
        chk("R6 cause", {31'd0, status[4]}, 32'd1);
        wr(8'h10);
        chk("R6 clear", {24'd0, status[15:8]}, 32'h50);
        chk("R6 cause clr", {31'd0, status[4]}, 32'd0);

        // R7: framing error sticky
        err_evt = 5'b00100; cyc(); err_evt = '0; cyc();
        chk("R7 framing", {31'd0, status[19]}, 32'd1);
        chk("R7 cause", {31'd0, status[0]}, 32'd1);
        wr(8'h01);
        chk("R7 clear", {31'd0, status[19]}, 32'd0);

        // R8: masking of transmit space
        wr(8'h1F);
        tx_count = 10'd100; cyc(); tx_count = 10'd0; cyc();
        irq_en = 4'b1101; #1;
        chk("R8 masked", {31'd0, irq}, 32'd0);
        irq_en = 4'b0010; #1;
        chk("R8 enabled", {31'd0, irq}, 32'd1);

        // random phase against the reference
        for (int n = 0; n < 4000; n++) begin
            if (n % 64 == 0) begin
                irq_en = 4'($urandom); tx_lvl = 3'($urandom); rx_lvl = 3'($urandom);
            end
            if ($urandom % 3 == 0) rx_count = 10'($urandom);
            if ($urandom % 3 == 0) tx_count = ($urandom % 4 == 0) ? 10'd0 : 10'($urandom);
            tx_busy    = 1'($urandom);
            rx_timeout = ($urandom % 4 == 0) ? ~rx_timeout : rx_timeout;
            err_evt    = ($urandom % 8 == 0) ? 5'($urandom) : 5'd0;
            if ($urandom % 10 == 0) modem_in = 4'($urandom);
            wr_en   = ($urandom % 4 == 0);
            wr_byte = 8'($urandom);
            cyc();
            chk("R1 cause", {27'd0, status[4:0]}, {27'd0, m_pend});
            chk("R6 modem", {24'd0, status[15:8]}, {24'd0, m_lvl, m_delta});
            chk("R7 line", {24'd0, status[23:16]}, {24'd0, m_line()});
            chk("R9 count", {22'd0, status[31:24], status[7:6]}, {22'd0, rx_count[7:0], rx_count[9:8]});
            chk("R9 rsvd", {31'd0, status[5]}, 32'd0);
            chk("R8 irq", {31'd0, irq}, {31'd0, m_irq()});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule